// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a four-beat burst on a synchronous pipelined memory. When either of two active-low address strobes is sampled low, the full external address is captured and becomes the start of a new burst. On each following clock where both strobes are high and the active-low advance input is low, the sequencer moves to the next word of the burst. When advance is high, the address is held and the cycle acts as a wait state.

Only the low two address bits change within a burst, so the burst stays inside the aligned four-word block that holds its start address. A static order input picks the sequence. When it is high, the offsets are applied with XOR, which gives the interleaved order. When it is low, the offsets are added modulo four, which gives the linear order. The output is registered and is valid from the clock edge that loaded or stepped it.

Top module: `burst_addr_gen`

## Requirements
- R1: While rstN is low, curAddr is cleared to zero at the clock edge.
- R2: On a rising edge where procStrobeN is low, ctrlStrobeN is low, or both are low, curAddr takes the value of extAddr.
- R3: On a load edge the advance input has no effect: curAddr equals extAddr even when advanceN is low.
- R4: On an edge where both strobes are high and advanceN is low, curAddr moves to the next address of the burst, which always differs from the current one.
- R5: On an edge where both strobes are high and advanceN is high, curAddr keeps its value.
- R6: With interleave high, the low two bits after the first, second and third advance are the start bits XOR 1, XOR 2 and XOR 3.
- R7: With interleave low, the low two bits after the first, second and third advance are the start bits plus 1, plus 2 and plus 3, modulo 4.
- R8: Between loads, bits above bit 1 of curAddr never change, and no carry passes out of the low two bits.
- R9: The fourth advance after a load returns curAddr to the start address, and further advances cycle through the same four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| procStrobeN | input | 1 | First address strobe, active low, loads extAddr |
| ctrlStrobeN | input | 1 | Second address strobe, active low, loads extAddr |
| advanceN | input | 1 | Step to the next burst word, active low |
| interleave | input | 1 | Burst order: 1 = XOR order, 0 = linear order |
| extAddr | input | ADDR_W (16) | External start address |
| curAddr | output | ADDR_W (16) | Current access address |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a 2-bit wrap field. With these values the directed start addresses can sit just below a carry boundary of the upper bits, such as 0x00FE, where a carry leaking out of the low field would show at once. The four-word wrap keeps the full cycle back to the start to four advances, so every offset in both orders, and the return to the start, is covered in short bursts. A long mixed-stimulus phase then interleaves loads from both strobes, wait states and changes of order against the reference model.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Strobes from the control decoder to the address datapath
  typedef struct packed {
    logic load;   // capture external address
    logic step;   // move to next burst word
  } burstCtl_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic      procStrobeN,
  input  logic      ctrlStrobeN,
  input  logic      advanceN,
  output burstCtl_t ctl
);

  logic anyStrobe;

  always_comb begin
    anyStrobe = ~procStrobeN | ~ctrlStrobeN;
    ctl.load  = anyStrobe;
    // advance only counts when no strobe starts a new cycle
    ctl.step  = ~anyStrobe & ~advanceN;
  end

endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int WRAP_W = 2
) (
  input  logic [WRAP_W-1:0] startLow,
  input  logic [WRAP_W-1:0] beat,
  input  logic              interleave,
  output logic [WRAP_W-1:0] lowBits
);

  logic [WRAP_W-1:0] xorBits;
  logic [WRAP_W-1:0] sumBits;

  always_comb begin
    xorBits = startLow ^ beat;
    sumBits = startLow + beat;   // wraps modulo 2**WRAP_W
    lowBits = interleave ? xorBits : sumBits;
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WRAP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int UPPER_W = ADDR_W - WRAP_W;

  logic [WRAP_W-1:0]  startLow;
  logic [WRAP_W-1:0]  beatCnt;
  logic [WRAP_W-1:0]  nextBeat;
  logic [WRAP_W-1:0]  nextLow;
  logic [UPPER_W-1:0] upperReg;
  logic [WRAP_W-1:0]  lowReg;

  assign nextBeat = beatCnt + 1'b1;

  burst_order #(.WRAP_W(WRAP_W)) u_order (
    .startLow  (startLow),
    .beat      (nextBeat),
    .interleave(interleave),
    .lowBits   (nextLow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperReg <= '0;
      lowReg   <= '0;
      startLow <= '0;
      beatCnt  <= '0;
    end else if (ctl.load) begin
      upperReg <= extAddr[ADDR_W-1:WRAP_W];
      lowReg   <= extAddr[WRAP_W-1:0];
      startLow <= extAddr[WRAP_W-1:0];
      beatCnt  <= '0;
    end else if (ctl.step) begin
      lowReg   <= nextLow;
      beatCnt  <= nextBeat;
    end
  end

  assign curAddr = {upperReg, lowReg};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WRAP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);

  burstCtl_t ctl;

  burst_ctrl u_ctrl (
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .advanceN   (advanceN),
    .ctl        (ctl)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .interleave(interleave),
    .extAddr   (extAddr),
    .curAddr   (curAddr)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int WRAP_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] curAddr
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> curAddr == '0);

  // R2 R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN || !ctrlStrobeN) |=> curAddr == $past(extAddr));

  // R4
  advance_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && ctrlStrobeN && !advanceN) |=> curAddr != $past(curAddr));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && ctrlStrobeN && advanceN) |=> $stable(curAddr));

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && ctrlStrobeN) |=>
      curAddr[ADDR_W-1:WRAP_W] == $past(curAddr[ADDR_W-1:WRAP_W]));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .procStrobeN(procStrobeN),
  .ctrlStrobeN(ctrlStrobeN),
  .advanceN   (advanceN),
  .extAddr    (extAddr),
  .curAddr    (curAddr)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        procStrobeN = 1'b1;
  logic        ctrlStrobeN = 1'b1;
  logic        advanceN = 1'b1;
  logic        interleave = 1'b1;
  logic [15:0] extAddr = '0;
  logic [15:0] curAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int refAddr = 0;
  int refStart = 0;
  int refBeat = 0;

  always #10 clk = ~clk;

  burst_addr_gen u0 (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .interleave(interleave), .extAddr(extAddr), .curAddr(curAddr)
  );

  task automatic check(input string tag, input int expv);
    checks++;
    if (int'(curAddr) != expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, curAddr, expv[15:0]);
    end
  endtask

  // drive one cycle at the falling edge, update model at the rising edge,
  // compare against the model at the next falling edge
  task automatic cyc(input logic p, input logic c, input logic a, input logic m,
                     input int e, input string tag);
    int low;
    procStrobeN = p; ctrlStrobeN = c; advanceN = a; interleave = m;
    extAddr = e[15:0];
    @(posedge clk);
    if (!rstN) begin
      refAddr = 0; refStart = 0; refBeat = 0;
    end else if (!p || !c) begin
      refAddr = e & 16'hFFFF; refStart = e % 4; refBeat = 0;
    end else if (!a) begin
      refBeat = (refBeat + 1) % 4;
      low = m ? (refStart ^ refBeat) : ((refStart + refBeat) % 4);
      refAddr = (refAddr & 16'hFFFC) | low;
    end
    @(negedge clk);
    check(tag, refAddr);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 0, 1, 16'hABCD, "R1");
    cyc(0, 1, 1, 1, 16'h5555, "R1");
    check("R1", 0);
    rstN = 1'b1;

    // interleaved burst from 0x1235 via first strobe, advance low on load edge
    cyc(0, 1, 0, 1, 16'h1235, "R3");
    check("R3", 16'h1235);
    cyc(1, 1, 0, 1, 0, "R6");  check("R6", 16'h1234);
    cyc(1, 1, 1, 1, 0, "R5");  check("R5", 16'h1234);
    cyc(1, 1, 0, 1, 0, "R6");  check("R6", 16'h1237);
    cyc(1, 1, 0, 1, 0, "R6");  check("R6", 16'h1236);
    cyc(1, 1, 0, 1, 0, "R9");  check("R9", 16'h1235);
    cyc(1, 1, 0, 1, 0, "R9");  check("R9", 16'h1234);

    // linear burst near a carry boundary via second strobe
    cyc(1, 0, 1, 0, 16'h00FE, "R2");
    check("R2", 16'h00FE);
    cyc(1, 1, 0, 0, 0, "R7");  check("R7", 16'h00FF);
    cyc(1, 1, 0, 0, 0, "R8");  check("R8", 16'h00FC);
    cyc(1, 1, 0, 0, 0, "R7");  check("R7", 16'h00FD);
    cyc(1, 1, 0, 0, 0, "R9");  check("R9", 16'h00FE);

    // both strobes low together
    cyc(0, 0, 0, 1, 16'hF00F, "R2");
    check("R2", 16'hF00F);
    cyc(1, 1, 1, 1, 16'h0000, "R5"); check("R5", 16'hF00F);

    // mixed stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      logic p, c, a, m;
      p = ($urandom % 8) != 0;
      c = ($urandom % 8) != 0;
      a = $urandom % 2;
      m = (i / 500) % 2;
      cyc(p, c, a, m, int'($urandom % 65536), "R4");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule